// File: doc/BRIEF.md
# Extended-Format Result Rounder

This block is the final stage of a floating-point datapath. An arithmetic unit hands it an unrounded result in the 80-bit extended layout. That result is a sign bit, a 15-bit biased exponent and a 64-bit significand with an explicit integer bit, plus a guard bit and a sticky bit that stand for the part already shifted out below the significand. The block rounds that value to the precision the control word selects, which is 24, 53 or 64 significand bits. It uses one of four rounding directions and clears every significand bit below the kept precision.

When rounding carries out of the top significand bit, the block renormalizes. It also detects exponent overflow and raises two exception events for the status logic: one for an inexact result and one for overflow. If the overflow exception is masked, the block returns an infinity with the correct sign. The result is registered, and a valid strobe follows the input strobe by exactly one clock.

Top module: `fp_round_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock, and it is 0 after reset. Every output is 0 after reset.
- R2: On an accepted input, `out_se[15]` is the input sign and `out_se[14:0]` is the result exponent.
- R3: `prec_sel` chooses how many significand bits are kept: 2'b00 keeps 24, 2'b10 keeps 53, and 2'b11 and the reserved 2'b01 keep 64. Output significand bits below the kept ones are 0, so bits [39:0] are 0 for 24 bits and bits [10:0] are 0 for 53 bits.
- R4: With `rnd_mode` 2'b00, the kept value is incremented when the first discarded bit is 1 and either a lower discarded bit is 1 or the kept LSB is 1, so ties go to even.
- R5: With `rnd_mode` 2'b01 (toward minus infinity), the value is incremented exactly when the result is inexact and the sign is 1.
- R6: With `rnd_mode` 2'b10 (toward plus infinity), the value is incremented exactly when the result is inexact and the sign is 0.
- R7: With `rnd_mode` 2'b11 (toward zero), the value is never incremented, and the exponent leaves unchanged unless overflow substitution applies.
- R8: If the increment carries out of significand bit 63, the significand becomes 64'h8000_0000_0000_0000 and the exponent rises by one.
- R9: `out_inexact` is 1 exactly when a discarded significand bit, the guard bit or the sticky bit is 1, or when a masked overflow substitutes infinity.
- R10: `out_overflow` is 1 when the exponent after rounding is 15'h7FFF or larger. If `ovf_mask` is 1, the output becomes infinity: the input sign, exponent 15'h7FFF and significand 64'h8000_0000_0000_0000.
- R11: On an unmasked overflow, the rounded significand is delivered unchanged with the low 15 bits of the incremented exponent.
- R12: While `in_valid` is 0, the data and flag outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input result present |
| in_sign | input | 1 | Sign of unrounded result |
| in_exp | input | 15 | Biased exponent |
| in_sig | input | 64 | Significand with explicit integer bit |
| in_guard | input | 1 | First bit below the significand |
| in_sticky | input | 1 | OR of all bits below the guard bit |
| rnd_mode | input | 2 | Rounding direction code |
| prec_sel | input | 2 | Precision code |
| ovf_mask | input | 1 | 1 = overflow masked, deliver infinity |
| out_valid | output | 1 | Result present |
| out_se | output | 16 | Sign and exponent of rounded result |
| out_sig | output | 64 | Rounded significand |
| out_inexact | output | 1 | Precision exception event |
| out_overflow | output | 1 | Overflow exception event |

## Verification
The assertions check the following on every cycle:
- the one-clock valid timing;
- sign pass-through;
- cleared low bits at single and double precision;
- an unchanged exponent under truncation;
- exact pass-through of representable extended inputs;
- the infinity form of any masked overflow.

Only the bench scenarios can show that the increment decision is right under each rounding direction, including ties to even and sign-dependent directed rounding. The same holds for renormalization on carry, the exponent reaching overflow through a carry, and outputs holding while no input is offered. These are compared against a reference model written in the bench.

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int SIG_W    = 64,
  parameter int EXP_W    = 15,
  parameter int SGL_KEEP = 24,
  parameter int DBL_KEEP = 53
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sign,
  input  logic [EXP_W-1:0]   in_exp,
  input  logic [SIG_W-1:0]   in_sig,
  input  logic               in_guard,
  input  logic               in_sticky,
  input  logic [1:0]         rnd_mode,
  input  logic [1:0]         prec_sel,
  input  logic               ovf_mask,
  output logic               out_valid,
  output logic [EXP_W:0]     out_se,
  output logic [SIG_W-1:0]   out_sig,
  output logic               out_inexact,
  output logic               out_overflow
);
  localparam int SGL_DROP = SIG_W - SGL_KEEP;
  localparam int DBL_DROP = SIG_W - DBL_KEEP;
  localparam logic [SIG_W-1:0] ONE     = {{(SIG_W-1){1'b0}}, 1'b1};
  localparam logic [SIG_W-1:0] SGL_LSB = ONE << SGL_DROP;
  localparam logic [SIG_W-1:0] DBL_LSB = ONE << DBL_DROP;
  localparam logic [SIG_W-1:0] TOP_BIT = ONE << (SIG_W - 1);
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  logic             ext_prec;
  logic [SIG_W-1:0] lsb_unit, rbit_mask, low_mask, keep_mask;
  logic             round_b, sticky_b, lsb_b, inexact_raw, inc;
  logic [SIG_W:0]   sum;
  logic             carry;
  logic [SIG_W-1:0] sig_r;
  logic [EXP_W:0]   exp_sum;
  logic             ovf, sub_inf;

  assign ext_prec  = prec_sel[0];
  assign lsb_unit  = (prec_sel == 2'b00) ? SGL_LSB :
                     (prec_sel == 2'b10) ? DBL_LSB : ONE;
  assign rbit_mask = lsb_unit >> 1;
  assign low_mask  = rbit_mask - ONE;
  assign keep_mask = ~(lsb_unit - ONE);

  assign round_b   = ext_prec ? in_guard : |(in_sig & rbit_mask);
  assign sticky_b  = ext_prec ? in_sticky
                              : (|(in_sig & low_mask)) | in_guard | in_sticky;
  assign lsb_b     = |(in_sig & lsb_unit);
  assign inexact_raw = round_b | sticky_b;

  always_comb begin
    case (rnd_mode)
      2'b00:   inc = round_b & (sticky_b | lsb_b);
      2'b01:   inc = inexact_raw & in_sign;
      2'b10:   inc = inexact_raw & ~in_sign;
      default: inc = 1'b0;
    endcase
  end

  assign sum     = {1'b0, in_sig & keep_mask} + (inc ? {1'b0, lsb_unit} : '0);
  assign carry   = sum[SIG_W];
  assign sig_r   = carry ? TOP_BIT : sum[SIG_W-1:0];
  assign exp_sum = {1'b0, in_exp} + {{EXP_W{1'b0}}, carry};
  assign ovf     = exp_sum >= {1'b0, EXP_MAX};
  assign sub_inf = ovf & ovf_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_se       <= '0;
      out_sig      <= '0;
      out_inexact  <= 1'b0;
      out_overflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_se       <= {in_sign, sub_inf ? EXP_MAX : exp_sum[EXP_W-1:0]};
        out_sig      <= sub_inf ? TOP_BIT : sig_r;
        out_inexact  <= inexact_raw | sub_inf;
        out_overflow <= ovf;
      end
    end
  end
endmodule

module fp_round_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_sign,
  input logic [14:0] in_exp,
  input logic [63:0] in_sig,
  input logic        in_guard,
  input logic        in_sticky,
  input logic [1:0]  rnd_mode,
  input logic [1:0]  prec_sel,
  input logic        ovf_mask,
  input logic        out_valid,
  input logic [15:0] out_se,
  input logic [63:0] out_sig,
  input logic        out_inexact,
  input logic        out_overflow
);
  a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_sign_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_se[15] == $past(in_sign));
  a_r3_single_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec_sel == 2'b00) |=> out_sig[39:0] == 40'd0);
  a_r3_double_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec_sel == 2'b10) |=> out_sig[10:0] == 11'd0);
  a_r7_trunc_exp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rnd_mode == 2'b11 && in_exp != 15'h7fff)
      |=> out_se[14:0] == $past(in_exp));
  a_r9_exact_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec_sel[0] && !in_guard && !in_sticky && in_exp != 15'h7fff)
      |=> (!out_inexact && out_sig == $past(in_sig)));
  a_r10_masked_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf_mask) |=> (!out_overflow ||
      (out_se[14:0] == 15'h7fff && out_sig == 64'h8000_0000_0000_0000 && out_inexact)));
endmodule

bind fp_round_unit fp_round_unit_chk u_chk (.*);

// File: tb/fp_round_unit_bench.sv
`timescale 1ns/1ps
module fp_round_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sign = 1'b0, in_guard = 1'b0, in_sticky = 1'b0, ovf_mask = 1'b0;
  logic [14:0] in_exp = '0;
  logic [63:0] in_sig = '0;
  logic [1:0]  rnd_mode = '0, prec_sel = '0;
  logic        out_valid, out_inexact, out_overflow;
  logic [15:0] out_se;
  logic [63:0] out_sig;
  int checks = 0, fails = 0;
  int unsigned seed = 32'd20240611;

  fp_round_unit u_fp_round_unit (.*);

  always #2.5 clk = ~clk;

  function automatic logic [81:0] ref_round(input logic s, input logic [14:0] e,
      input logic [63:0] m, input logic g, input logic st, input logic [1:0] rm,
      input logic [1:0] pc, input logic mk);
    int drop;
    logic [64:0] kept;
    logic rb, sb, inex, up, ov;
    logic [15:0] ex;
    logic [63:0] mo;
    drop = (pc == 2'b00) ? 40 : (pc == 2'b10) ? 11 : 0;
    kept = {1'b0, m} >> drop;
    if (drop == 0) begin rb = g; sb = st; end
    else begin
      rb = m[drop-1];
      sb = g | st | ((m & ((64'd1 << (drop-1)) - 64'd1)) != 64'd0);
    end
    inex = rb | sb;
    case (rm)
      2'b00: up = rb & (sb | kept[0]);
      2'b01: up = inex & s;
      2'b10: up = inex & ~s;
      default: up = 1'b0;
    endcase
    kept = kept + {64'd0, up};
    ex = {1'b0, e};
    if ((kept >> (64 - drop)) != 65'd0) begin
      kept = 65'd1 << (63 - drop);
      ex = ex + 16'd1;
    end
    mo = kept[63:0] << drop;
    ov = ex >= 16'h7fff;
    if (ov && mk) return {s, 15'h7fff, 64'h8000_0000_0000_0000, 1'b1, 1'b1};
    return {s, ex[14:0], mo, inex, ov};
  endfunction

  task automatic check(input string req, input logic [81:0] act, input logic [81:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic s, input logic [14:0] e,
      input logic [63:0] m, input logic g, input logic st, input logic [1:0] rm,
      input logic [1:0] pc, input logic mk);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = e; in_sig = m; in_guard = g;
    in_sticky = st; rnd_mode = rm; prec_sel = pc; ovf_mask = mk;
    @(posedge clk); #1;
    check(req, {out_se, out_sig, out_inexact, out_overflow},
          ref_round(s, e, m, g, st, rm, pc, mk));
    check("R1", {81'd0, out_valid}, 82'd1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [81:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {out_se, out_sig, out_inexact, out_overflow, out_valid}[81:0], 82'd0);
    @(negedge clk); rst_n = 1'b1;

    apply("R4 tie to even low", 0, 15'h3fff, 64'h8000_0000_0000_0000, 1, 0, 2'b00, 2'b11, 0);
    apply("R4 tie to even up", 0, 15'h3fff, 64'h8000_0000_0000_0001, 1, 0, 2'b00, 2'b11, 0);
    apply("R4 above half", 0, 15'h3fff, 64'h8000_0000_0000_0000, 1, 1, 2'b00, 2'b11, 0);
    apply("R4 single tie", 0, 15'h4000, 64'hC000_0080_0000_0000, 0, 0, 2'b00, 2'b00, 0);
    apply("R5 neg down", 1, 15'h4000, 64'hC000_0000_0000_0001, 0, 0, 2'b01, 2'b10, 0);
    apply("R5 pos down", 0, 15'h4000, 64'hC000_0000_0000_0001, 0, 0, 2'b01, 2'b10, 0);
    apply("R6 pos up", 0, 15'h4000, 64'hC000_0000_0000_0001, 0, 0, 2'b10, 2'b10, 0);
    apply("R6 neg up", 1, 15'h4000, 64'hC000_0000_0000_0001, 0, 0, 2'b10, 2'b10, 0);
    apply("R7 trunc", 0, 15'h4000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 2'b11, 2'b00, 0);
    apply("R3 reserved code", 0, 15'h4000, 64'h8000_0000_0000_0003, 1, 1, 2'b00, 2'b01, 0);
    apply("R8 carry single", 0, 15'h1234, 64'hFFFF_FF80_0000_0000, 0, 0, 2'b00, 2'b00, 0);
    apply("R8 carry ext", 1, 15'h1234, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 2'b01, 2'b11, 0);
    apply("R9 exact", 1, 15'h2222, 64'hABCD_EF00_0000_0000, 0, 0, 2'b10, 2'b00, 0);
    apply("R10 masked ovf", 0, 15'h7ffe, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'b00, 2'b11, 1);
    apply("R11 unmasked ovf", 1, 15'h7ffe, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'b01, 2'b11, 0);
    apply("R10 no carry no ovf", 0, 15'h7ffe, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'b11, 2'b11, 1);

    held = {out_se, out_sig, out_inexact, out_overflow};
    @(negedge clk);
    in_sign = 1; in_exp = 15'h0001; in_sig = 64'h1; in_guard = 1; in_sticky = 1;
    @(posedge clk); #1;
    check("R12 hold", {out_se, out_sig, out_inexact, out_overflow}, held);
    check("R1 idle", {81'd0, out_valid}, 82'd0);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] m;
      logic [14:0] e;
      m = {$urandom(seed), $urandom(seed)};
      m[63] = 1'b1;
      if (i % 4 == 0) m[39:0] = {1'b1, 39'd0};
      if (i % 5 == 0) m[62:11] = '1;
      e = (i % 7 == 0) ? 15'h7ffe : 15'($urandom(seed) % 32767);
      apply("R4-R11 random", 1'($urandom(seed)), e, m, 1'($urandom(seed)),
            1'($urandom(seed)), 2'($urandom(seed)), 2'($urandom(seed)),
            1'($urandom(seed)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule